// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic core of a small accumulator-style datapath. It holds a working register W and a second operand register TEMP, both loadable from an external data bus. On each cycle where the execute strobe is high it applies the selected operation and writes the result back into W. It updates a status register of carry, zero and negative flags in the same clock edge.

Single-operand operations work on W alone: clear, invert, increment, decrement, negate, set a bit, clear a bit, rotate through carry and shift. Two-operand operations combine W with TEMP: add, add with carry, AND, OR and XOR. Add with carry folds in the stored carry flag, so a wide sum can be built one byte at a time, low byte first. The block does not decode instructions or access memory; a surrounding sequencer drives the strobes, the operation code and the bit index.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, W, TEMP, carry, zero and negative all read 0.
- R2: A rising clock edge with ld_w_i high and exec_i low loads W from data_i. A rising edge with ld_t_i high loads TEMP from data_i. Neither load changes any flag.
- R3: With exec_i, ld_w_i and ld_t_i all low, W, TEMP and the three flags hold their values.
- R4: Each unary arithmetic op_i code sets W to a fixed result and carry to a fixed value:
  - 0 CLR: W=0, carry=0.
  - 1 NOT: W=~W, carry=0.
  - 2 INC: W=W+1, carry=1 only when W was 0xFF.
  - 3 DEC: W=W-1, carry=1 only when W was 0x00.
  - 4 NEG: W=0-W, carry=1 when W was nonzero.
- R5: op_i 5 (SETB) sets bit bit_sel_i of W, and op_i 6 (CLRB) clears it. The other bits of W and the carry flag keep their values.
- R6: Rotates are 9 bits wide through carry. op_i 7 (ROL): new W = {W[6:0], carry}, new carry = old W[7]. op_i 8 (ROR): new W = {carry, W[7:1]}, new carry = old W[0].
- R7: Shifts fill with zero. op_i 9 (SHL): W = W<<1, carry = old W[7]. op_i 10 (SHR): W = W>>1, carry = old W[0].
- R8: op_i 11 (ADD) sets W = W+TEMP mod 256, with carry = unsigned carry out. op_i 12 (ADC) sets W = W+TEMP+carry, with carry = carry out.
- R9: op_i 13 (AND), 14 (OR) and 15 (XOR) set W to the bitwise result of W and TEMP and clear carry.
- R10: After every executed operation, zero is 1 exactly when the new W is 0x00.
- R11: After every executed operation, negative equals bit 7 of the new W.
- R12: When exec_i and ld_w_i are both high, the operation result is written to W and data_i is ignored for W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code (see R4 to R9) |
| bit_sel_i | input | 3 | Bit index for SETB/CLRB |
| exec_i | input | 1 | Execute strobe: write result to W and update flags |
| ld_w_i | input | 1 | Load W from data_i |
| ld_t_i | input | 1 | Load TEMP from data_i |
| data_i | input | 8 | External data bus |
| w_o | output | 8 | Working register W |
| temp_o | output | 8 | Operand register TEMP |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |

## Verification
The bench builds the block with its default width of 8 bits. At that width, random operands reach the wrap points 0x00, 0xFF and 0x80 often enough that increment, decrement, negate and add carries are all exercised, along with changes of the sign bit. Directed cases add a 16-bit addition built from ADD then ADC, rotates of carry into and out of both ends, and a load strobe that collides with execute.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_CLR  = 4'd0,
        OP_NOT  = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_NEG  = 4'd4,
        OP_SETB = 4'd5,
        OP_CLRB = 4'd6,
        OP_ROL  = 4'd7,
        OP_ROR  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10,
        OP_ADD  = 4'd11,
        OP_ADC  = 4'd12,
        OP_AND  = 4'd13,
        OP_OR   = 4'd14,
        OP_XOR  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
    } alu_flags_t;

    function automatic logic uses_temp(alu_op_e op);
        return op inside {OP_ADD, OP_ADC, OP_AND, OP_OR, OP_XOR};
    endfunction

endpackage

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] w,
    input  logic             cin,
    input  logic [IDXW-1:0]  bsel,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] mask;
    logic [WIDTH:0]   inc_sum;

    assign mask    = ONE << bsel;
    assign inc_sum = {1'b0, w} + {1'b0, ONE};

    always_comb begin
        res  = w;
        cout = cin;
        case (op)
            OP_CLR: begin
                res  = '0;
                cout = 1'b0;
            end
            OP_NOT: begin
                res  = ~w;
                cout = 1'b0;
            end
            OP_INC: begin
                res  = inc_sum[WIDTH-1:0];
                cout = inc_sum[WIDTH];
            end
            OP_DEC: begin
                res  = w - ONE;
                cout = (w == '0);
            end
            OP_NEG: begin
                res  = '0 - w;
                cout = (w != '0);
            end
            OP_SETB: res = w | mask;
            OP_CLRB: res = w & ~mask;
            OP_ROL: begin
                res  = {w[WIDTH-2:0], cin};
                cout = w[WIDTH-1];
            end
            OP_ROR: begin
                res  = {cin, w[WIDTH-1:1]};
                cout = w[0];
            end
            OP_SHL: begin
                res  = {w[WIDTH-2:0], 1'b0};
                cout = w[WIDTH-1];
            end
            OP_SHR: begin
                res  = {1'b0, w[WIDTH-1:1]};
                cout = w[0];
            end
            default: begin
                res  = w;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/acc_alu_binary.sv
module acc_alu_binary
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] w,
    input  logic [WIDTH-1:0] t,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    logic [WIDTH:0] sum;
    logic           cadd;

    assign cadd = (op == OP_ADC) ? cin : 1'b0;
    assign sum  = {1'b0, w} + {1'b0, t} + {{WIDTH{1'b0}}, cadd};

    always_comb begin
        res  = w;
        cout = 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                res  = sum[WIDTH-1:0];
                cout = sum[WIDTH];
            end
            OP_AND:  res = w & t;
            OP_OR:   res = w | t;
            OP_XOR:  res = w ^ t;
            default: res = w;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDXW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [IDXW-1:0]  bit_sel_i,
    input  logic             exec_i,
    input  logic             ld_w_i,
    input  logic             ld_t_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] w_o,
    output logic [WIDTH-1:0] temp_o,
    output logic             carry_o,
    output logic             zero_o,
    output logic             neg_o
);
    typedef struct packed {
        logic [WIDTH-1:0] w;
        logic [WIDTH-1:0] t;
        alu_flags_t       f;
    } acc_state_t;

    acc_state_t state_d, state_q;

    alu_op_e          op;
    logic [WIDTH-1:0] un_res, bin_res, res;
    logic             un_c, bin_c, res_c;

    assign op = alu_op_e'(op_i);

    acc_alu_unary #(.WIDTH(WIDTH)) u_unary (
        .op   (op),
        .w    (state_q.w),
        .cin  (state_q.f.c),
        .bsel (bit_sel_i),
        .res  (un_res),
        .cout (un_c)
    );

    acc_alu_binary #(.WIDTH(WIDTH)) u_binary (
        .op   (op),
        .w    (state_q.w),
        .t    (state_q.t),
        .cin  (state_q.f.c),
        .res  (bin_res),
        .cout (bin_c)
    );

    always_comb begin
        if (uses_temp(op)) begin
            res   = bin_res;
            res_c = bin_c;
        end else begin
            res   = un_res;
            res_c = un_c;
        end
    end

    always_comb begin
        state_d = state_q;
        if (exec_i) begin
            state_d.w   = res;
            state_d.f.c = res_c;
            state_d.f.z = (res == '0);
            state_d.f.n = res[WIDTH-1];
        end else if (ld_w_i) begin
            state_d.w = data_i;
        end
        if (ld_t_i) begin
            state_d.t = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign w_o     = state_q.w;
    assign temp_o  = state_q.t;
    assign carry_o = state_q.f.c;
    assign zero_o  = state_q.f.z;
    assign neg_o   = state_q.f.n;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic             exec_i,
    input logic             ld_w_i,
    input logic             ld_t_i,
    input logic [WIDTH-1:0] data_i,
    input logic [WIDTH-1:0] w_o,
    input logic [WIDTH-1:0] temp_o,
    input logic             carry_o,
    input logic             zero_o,
    input logic             neg_o
);
    p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i |=> (zero_o == (w_o == '0)));

    p_neg_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i |=> (neg_o == w_o[WIDTH-1]));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_i && !ld_w_i && !ld_t_i) |=>
            ($stable(w_o) && $stable(temp_o) && $stable(carry_o) &&
             $stable(zero_o) && $stable(neg_o)));

    p_load_w_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_w_i && !exec_i) |=>
            (w_o == $past(data_i) && $stable(carry_o) && $stable(zero_o) && $stable(neg_o)));

    p_load_t_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_t_i |=> (temp_o == $past(data_i)));

    p_logic_clears_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i >= 4'd13) |=> !carry_o);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == 4'd0) |=> (w_o == '0 && !carry_o && zero_o));
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .exec_i  (exec_i),
    .ld_w_i  (ld_w_i),
    .ld_t_i  (ld_t_i),
    .data_i  (data_i),
    .w_o     (w_o),
    .temp_o  (temp_o),
    .carry_o (carry_o),
    .zero_o  (zero_o),
    .neg_o   (neg_o)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   op_i = '0;
    logic [2:0]   bit_sel_i = '0;
    logic         exec_i = 1'b0, ld_w_i = 1'b0, ld_t_i = 1'b0;
    logic [W-1:0] data_i = '0;
    logic [W-1:0] w_o, temp_o;
    logic         carry_o, zero_o, neg_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] m_w = '0, m_t = '0;
    logic m_c = 1'b0, m_z = 1'b0, m_n = 1'b0;

    always #4 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .bit_sel_i(bit_sel_i),
        .exec_i(exec_i), .ld_w_i(ld_w_i), .ld_t_i(ld_t_i), .data_i(data_i),
        .w_o(w_o), .temp_o(temp_o), .carry_o(carry_o), .zero_o(zero_o), .neg_o(neg_o)
    );

    // Returns {carry, result} from the requirement text
    function automatic logic [W:0] model(input logic [3:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic c,
                                         input logic [2:0] k);
        logic [W:0] s;
        case (op)
            4'd0:  return {1'b0, 8'h00};
            4'd1:  return {1'b0, ~a};
            4'd2:  return {a == 8'hFF, a + 8'd1};
            4'd3:  return {a == 8'h00, a - 8'd1};
            4'd4:  return {a != 8'h00, 8'd0 - a};
            4'd5:  return {c, a | (8'd1 << k)};
            4'd6:  return {c, a & ~(8'd1 << k)};
            4'd7:  return {a[7], a[6:0], c};
            4'd8:  return {a[0], c, a[7:1]};
            4'd9:  return {a[7], a[6:0], 1'b0};
            4'd10: return {a[0], 1'b0, a[7:1]};
            4'd11: begin s = {1'b0, a} + {1'b0, b}; return s; end
            4'd12: begin s = {1'b0, a} + {1'b0, b} + {8'd0, c}; return s; end
            4'd13: return {1'b0, a & b};
            4'd14: return {1'b0, a | b};
            default: return {1'b0, a ^ b};
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic ex,
                                     input logic lw, input logic lt);
        if (ex && lw) return "R12";
        if (!ex) return (lw || lt) ? "R2" : "R3";
        if (op <= 4'd4) return "R4";
        if (op <= 4'd6) return "R5";
        if (op <= 4'd8) return "R6";
        if (op <= 4'd10) return "R7";
        if (op <= 4'd12) return "R8";
        return "R9";
    endfunction

    task automatic check(input string tag);
        checks++;
        if (w_o !== m_w || temp_o !== m_t || carry_o !== m_c ||
            zero_o !== m_z || neg_o !== m_n) begin
            errors++;
            $display("FAIL %s: w=%h t=%h c%b z%b n%b expected w=%h t=%h c%b z%b n%b (R10/R11 flags)",
                     tag, w_o, temp_o, carry_o, zero_o, neg_o, m_w, m_t, m_c, m_z, m_n);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [2:0] k, input logic ex,
                        input logic lw, input logic lt, input logic [W-1:0] d);
        logic [W:0] r;
        @(negedge clk);
        op_i = op; bit_sel_i = k; exec_i = ex; ld_w_i = lw; ld_t_i = lt; data_i = d;
        r = model(op, m_w, m_t, m_c, k);
        @(posedge clk);
        if (ex) begin
            m_w = r[W-1:0]; m_c = r[W]; m_z = (r[W-1:0] == 8'h00); m_n = r[W-1];
        end else if (lw) m_w = d;
        if (lt) m_t = d;
        #2;
        check(tag_of(op, ex, lw, lt));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        #10;
        check("R1");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2; check("R1");

        // R2 loads, then R8 16-bit sum 0x12FF + 0x3401 = 0x4700
        step(4'd0, 3'd0, 1'b0, 1'b1, 1'b1, 8'hFF);
        step(4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 8'h01);
        step(4'd11, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00);   // R8 low byte: 00, carry 1
        step(4'd0, 3'd0, 1'b0, 1'b1, 1'b1, 8'h12);
        step(4'd0, 3'd0, 1'b0, 1'b0, 1'b1, 8'h34);
        step(4'd12, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00);   // R8 high byte 0x47
        // R4 wraps
        step(4'd0, 3'd0, 1'b0, 1'b1, 1'b0, 8'hFF);
        step(4'd2, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00);    // INC FF -> 00, c=1
        step(4'd3, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00);    // DEC 00 -> FF, c=1
        step(4'd4, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00);    // NEG FF -> 01
        // R6 rotate carry around
        step(4'd0, 3'd0, 1'b0, 1'b1, 1'b0, 8'h80);
        step(4'd7, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00);
        step(4'd8, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00);
        // R5 bits keep carry
        step(4'd5, 3'd7, 1'b1, 1'b0, 1'b0, 8'h00);
        step(4'd6, 3'd7, 1'b1, 1'b0, 1'b0, 8'h00);
        // R12 exec wins over load
        step(4'd1, 3'd0, 1'b1, 1'b1, 1'b0, 8'hA5);
        // R3 idle
        step(4'd0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h3C);
        // R9 logic clears carry
        step(4'd9, 3'd0, 1'b0, 1'b1, 1'b1, 8'hC3);
        step(4'd9, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00);
        step(4'd15, 3'd0, 1'b1, 1'b0, 1'b0, 8'h00);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[3:0], r[6:4], r[7] | r[8], r[9] & r[10], r[11] & r[12], r[20:13]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule